// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent up-counters behind a simple register bus. Each channel has its own set of registers. Each channel counts ticks that come from either the bus clock or an external clock pin. A power-of-two prescaler can divide those ticks down. A channel either runs freely and wraps at its all-ones value, or runs in interval mode: it returns to zero after reaching a programmed period and raises an event flag. Each channel drives its own interrupt line.

Software sets up a channel while it is halted. It then writes the run control register with the restart bit set, which times the new period in full from zero. Reading a channel's event flags acknowledges them, so no write is needed to clear them.

Top module: `tmr3_top`

## Requirements
- R1: Channel n (n = 0, 1, 2) has its registers at the channel 0 byte offset plus 4·n. The channel 0 offsets are: scale control 0x00, run control 0x0C, count 0x18, period 0x24, event flags 0x54, event mask 0x60. Scale control holds 6 bits and reads back as written. Period holds CW bits (16 by default) and drops the upper write bits. The event mask holds bit 0. Run control bits 0, 1, 2, 3 and 5 read back as written.
- R2: After reset every channel has scale control 0, run control 0x21 (halted), count 0, period 0, flags 0 and mask 0, and all interrupt lines are low.
- R3: With scale control bit 0 clear, the count advances once per source tick. With bit 0 set, it advances once every 2^(P+1) source ticks, where P is scale control bits [4:1].
- R4: Scale control bit 5 = 0 takes source ticks from the bus clock. Bit 5 = 1 takes one source tick per rising edge of the channel's external clock pin, after a two-flop synchronizer. While bit 5 = 1, the bus clock does not advance the count.
- R5: Run control bit 0 = 1 freezes both the count and the prescaler phase.
- R6: Writing run control with bit 4 set zeroes the count and the prescaler phase in that cycle. Bit 4 always reads back as 0.
- R7: With run control bit 1 clear, the count wraps from all ones to zero and sets no flag.
- R8: With run control bit 1 set, a counting tick that finds the count equal to the period loads zero instead of count+1 and sets flag bit 0.
- R9: A read of the flags register returns the flag in bit 0 and clears it. If a new event arrives in the same cycle as the read, the flag stays set.
- R10: A channel's interrupt line is high exactly while its flag bit 0 and its mask bit 0 are both 1.
- R11: Writes to the count and flags registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reading the flags register clears them) |
| bus_addr | input | AW (8) | Byte address |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, combinational, zero when idle |
| ext_clk_in | input | NCH (3) | External clock pin per channel |
| irq_o | output | NCH (3) | Interrupt line per channel |

## Verification
The counting path is driven in four ways, and each one isolates a different source of error. The bus clock with no prescaling exposes an off-by-one in the advance. Division by four exposes an error in the phase mask or in how the prescaler phase is cleared. External pin edges show that only synchronized rising edges are counted and that bus clock ticks are ignored in that mode. A full 16-bit free-running wrap shows that the count rolls over without raising an event. In interval mode, the flags are read on cycles chosen so that one read lands exactly on a new event; this separates a design that keeps the colliding flag from one that loses it.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;

    // per-channel register offsets of channel 0; channel n adds n*CH_STRIDE
    localparam int unsigned OFF_SCALE  = 'h00;
    localparam int unsigned OFF_RUN    = 'h0C;
    localparam int unsigned OFF_COUNT  = 'h18;
    localparam int unsigned OFF_PERIOD = 'h24;
    localparam int unsigned OFF_FLAGS  = 'h54;
    localparam int unsigned OFF_MASK   = 'h60;
    localparam int unsigned CH_STRIDE  = 4;

    localparam int EXP_W = 4;            // prescale exponent field width
    localparam int PRE_W = 1 << EXP_W;   // prescaler phase counter width

    typedef struct packed {
        logic             src_ext;   // bit 5
        logic [EXP_W-1:0] exp;       // bits 4:1
        logic             pre_en;    // bit 0
    } scale_t;

    typedef struct packed {
        logic       wave_off;        // bit 5, stored only
        logic       restart;         // bit 4, always stored as 0
        logic [1:0] spare;           // bits 3:2, stored only
        logic       interval;        // bit 1
        logic       halt;            // bit 0
    } run_t;

    localparam logic [5:0] RUN_RESET = 6'h21;

    // low (e+1) bits set: prescaler phase at which a tick passes
    function automatic logic [PRE_W-1:0] phase_mask(input logic [EXP_W-1:0] e);
        logic [PRE_W:0] m;
        m = ({{PRE_W{1'b0}}, 1'b1} << (e + 5'd1)) - {{PRE_W{1'b0}}, 1'b1};
        return m[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr3_edge_sync.sv
module tmr3_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic pulse_o
);
    logic [2:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[1:0], async_i};
    end

    assign pulse_o = sh_q[1] & ~sh_q[2];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o); // R4

endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel
    import tmr3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  scale_t        scale_i,
    input  logic          halt_i,
    input  logic          interval_i,
    input  logic          restart_i,
    input  logic [CW-1:0] period_i,
    input  logic          ext_pulse_i,
    input  logic          flags_rd_i,
    output logic [CW-1:0] count_o,
    output logic          flag_o
);
    logic [PRE_W-1:0] phase_q;
    logic [CW-1:0]    cnt_q;
    logic             flag_q;
    logic             src_pulse, advance, tick, at_period, flag_set;
    logic [PRE_W-1:0] mask;

    assign mask      = phase_mask(scale_i.exp);
    assign src_pulse = scale_i.src_ext ? ext_pulse_i : 1'b1;
    assign advance   = src_pulse & ~halt_i;
    assign tick      = advance & (~scale_i.pre_en | ((phase_q & mask) == mask));
    assign at_period = interval_i & (cnt_q == period_i);
    assign flag_set  = tick & at_period & ~restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) phase_q <= '0;
        else if (advance)     phase_q <= phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) cnt_q <= '0;
        else if (tick)        cnt_q <= at_period ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_set | (flag_q & ~flags_rd_i);
    end

    assign count_o = cnt_q;
    assign flag_o  = flag_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == CW'($past(cnt_q) + 1'b1) || cnt_q == '0)); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (halt_i && !restart_i) |=> (cnt_q == $past(cnt_q))); // R5
    AST_PERIOD_ZERO: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> (cnt_q == '0)); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        flag_set |=> flag_q); // R9
    AST_READ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flags_rd_i && !flag_set) |=> !flag_q); // R9

endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
    import tmr3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int NCH = 3,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [NCH-1:0] ext_clk_in,
    output logic [NCH-1:0] irq_o
);
    logic [NCH-1:0][DW-1:0] rd_vals;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [AW-1:0] A_SCALE  = AW'(OFF_SCALE  + g * CH_STRIDE);
        localparam logic [AW-1:0] A_RUN    = AW'(OFF_RUN    + g * CH_STRIDE);
        localparam logic [AW-1:0] A_COUNT  = AW'(OFF_COUNT  + g * CH_STRIDE);
        localparam logic [AW-1:0] A_PERIOD = AW'(OFF_PERIOD + g * CH_STRIDE);
        localparam logic [AW-1:0] A_FLAGS  = AW'(OFF_FLAGS  + g * CH_STRIDE);
        localparam logic [AW-1:0] A_MASK   = AW'(OFF_MASK   + g * CH_STRIDE);

        scale_t        scale_q;
        run_t          run_q;
        logic [CW-1:0] period_q;
        logic          mask_q;
        logic          restart, ext_pulse, flags_rd, flag;
        logic [CW-1:0] count;
        logic [DW-1:0] rv;

        assign restart  = bus_wr & (bus_addr == A_RUN) & bus_wdata[4];
        assign flags_rd = bus_rd & (bus_addr == A_FLAGS);

        always_ff @(posedge clk) begin
            if (rst) begin
                scale_q  <= '0;
                run_q    <= run_t'(RUN_RESET);
                period_q <= '0;
                mask_q   <= 1'b0;
            end else if (bus_wr) begin
                if (bus_addr == A_SCALE)  scale_q  <= scale_t'(bus_wdata[5:0]);
                if (bus_addr == A_RUN)    run_q    <= '{wave_off: bus_wdata[5], restart: 1'b0,
                                                        spare: bus_wdata[3:2],
                                                        interval: bus_wdata[1], halt: bus_wdata[0]};
                if (bus_addr == A_PERIOD) period_q <= bus_wdata[CW-1:0];
                if (bus_addr == A_MASK)   mask_q   <= bus_wdata[0];
            end
        end

        tmr3_edge_sync u_sync (
            .clk     (clk),
            .rst     (rst),
            .async_i (ext_clk_in[g]),
            .pulse_o (ext_pulse)
        );

        tmr3_channel #(.CW(CW)) u_chan (
            .clk         (clk),
            .rst         (rst),
            .scale_i     (scale_q),
            .halt_i      (run_q.halt),
            .interval_i  (run_q.interval),
            .restart_i   (restart),
            .period_i    (period_q),
            .ext_pulse_i (ext_pulse),
            .flags_rd_i  (flags_rd),
            .count_o     (count),
            .flag_o      (flag)
        );

        always_comb begin
            rv = '0;
            if (bus_addr == A_SCALE)  rv = DW'(scale_q);
            if (bus_addr == A_RUN)    rv = DW'(run_q);
            if (bus_addr == A_COUNT)  rv = DW'(count);
            if (bus_addr == A_PERIOD) rv = DW'(period_q);
            if (bus_addr == A_FLAGS)  rv = DW'(flag);
            if (bus_addr == A_MASK)   rv = DW'(mask_q);
        end

        assign rd_vals[g] = rv;
        assign irq_o[g]   = flag & mask_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd)
            for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | rd_vals[i];
    end

endmodule

// File: tb/tmr3_top_bench.sv
module tmr3_top_bench;
    localparam int CW = 16, NCH = 3, AW = 8, DW = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] ext_clk_in = '0;
    logic [NCH-1:0] irq_o;
    int             total = 0, bad = 0;
    bit             done = 1'b0;

    always #10 clk = ~clk;

    tmr3_top #(.CW(CW), .NCH(NCH), .AW(AW), .DW(DW)) u_tmr3_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in), .irq_o(irq_o)
    );

    // ops: 1 write, 2 read+compare, 3 wait data cycles, 4 compare irq_o
    // fields: {op[3:0], addr[7:0], data[31:0], expect[31:0], requirement[7:0]}
    localparam int NV = 35;
    localparam logic [83:0] VEC [NV] = '{
        {4'd1, 8'h0C, 32'h10,    32'h0,    8'd3},   // R3 restart ch0 free-run
        {4'd3, 8'h00, 32'd9,     32'h0,    8'd3},
        {4'd2, 8'h18, 32'h0,     32'd9,    8'd3},   // R3 one per cycle
        {4'd1, 8'h0C, 32'h01,    32'h0,    8'd5},   // R5 halt
        {4'd3, 8'h00, 32'd5,     32'h0,    8'd5},
        {4'd2, 8'h18, 32'h0,     32'd11,   8'd5},   // R5 frozen
        {4'd1, 8'h18, 32'h1234,  32'h0,    8'd11},  // R11 write to count
        {4'd2, 8'h18, 32'h0,     32'd11,   8'd11},  // R11 unchanged
        {4'd1, 8'h0C, 32'h11,    32'h0,    8'd6},   // R6 restart while halted
        {4'd2, 8'h18, 32'h0,     32'd0,    8'd6},   // R6 zeroed
        {4'd2, 8'h0C, 32'h0,     32'h01,   8'd6},   // R6 bit 4 reads 0
        {4'd1, 8'h00, 32'h03,    32'h0,    8'd3},   // R3 divide by 4
        {4'd2, 8'h00, 32'h0,     32'h03,   8'd1},   // R1
        {4'd1, 8'h0C, 32'h10,    32'h0,    8'd3},
        {4'd3, 8'h00, 32'd22,    32'h0,    8'd3},
        {4'd2, 8'h18, 32'h0,     32'd5,    8'd3},   // R3 22/4
        {4'd1, 8'h24, 32'h1ABCD, 32'h0,    8'd1},   // R1 period width
        {4'd2, 8'h24, 32'h0,     32'hABCD, 8'd1},   // R1
        {4'd1, 8'h28, 32'd4,     32'h0,    8'd8},   // R8 ch1 period 4
        {4'd1, 8'h64, 32'h1,     32'h0,    8'd10},  // R10 mask on
        {4'd1, 8'h10, 32'h12,    32'h0,    8'd8},   // R8 restart interval
        {4'd2, 8'h10, 32'h0,     32'h02,   8'd1},   // R1 ch1 run control
        {4'd3, 8'h00, 32'd5,     32'h0,    8'd8},
        {4'd2, 8'h1C, 32'h0,     32'd1,    8'd8},   // R8 wrapped at 5
        {4'd4, 8'h00, 32'h0,     32'h2,    8'd10},  // R10 irq ch1
        {4'd2, 8'h58, 32'h0,     32'h1,    8'd9},   // R9 read+clear
        {4'd2, 8'h58, 32'h0,     32'h0,    8'd9},   // R9 cleared; collides with event
        {4'd4, 8'h00, 32'h0,     32'h2,    8'd9},   // R9 colliding event kept
        {4'd2, 8'h58, 32'h0,     32'h1,    8'd9},   // R9
        {4'd4, 8'h00, 32'h0,     32'h0,    8'd9},   // R9 cleared
        {4'd1, 8'h64, 32'h0,     32'h0,    8'd10},  // R10 mask off
        {4'd3, 8'h00, 32'd2,     32'h0,    8'd10},
        {4'd4, 8'h00, 32'h0,     32'h0,    8'd10},  // R10 masked
        {4'd2, 8'h58, 32'h0,     32'h1,    8'd10},  // R10 flag still set
        {4'd2, 8'h1C, 32'h0,     32'd3,    8'd8}    // R8 still cycling
    };

    task automatic check(input int req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_check(input int req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        read_check(2, 8'h00, 32'h0);
        read_check(2, 8'h0C, 32'h21);
        read_check(2, 8'h14, 32'h21);
        read_check(2, 8'h18, 32'h0);
        read_check(2, 8'h24, 32'h0);
        read_check(2, 8'h54, 32'h0);
        read_check(2, 8'h60, 32'h0);
        check(2, DW'(irq_o), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]    op;
            logic [AW-1:0] a;
            logic [DW-1:0] d, e;
            int            r;
            op = VEC[i][83:80]; a = VEC[i][79:72]; d = VEC[i][71:40];
            e  = VEC[i][39:8];  r = int'(VEC[i][7:0]);
            case (op)
                4'd1: bus_write(a, d);
                4'd2: read_check(r, a, e);
                4'd3: idle(int'(d));
                default: begin check(r, DW'(irq_o), e); @(negedge clk); end
            endcase
        end

        // R4 external clock on ch2
        bus_write(8'h08, 32'h20);
        bus_write(8'h14, 32'h10);
        idle(10);
        read_check(4, 8'h20, 32'd0);     // R4 bus clock ignored
        for (int k = 0; k < 5; k++) begin
            ext_clk_in[2] = 1'b1; idle(4);
            ext_clk_in[2] = 1'b0; idle(4);
        end
        idle(6);
        read_check(4, 8'h20, 32'd5);     // R4 one per rising edge

        // R7 full free-running wrap on ch0
        bus_write(8'h00, 32'h0);
        bus_write(8'h0C, 32'h10);
        idle(65538);
        read_check(7, 8'h18, 32'd2);
        read_check(7, 8'h54, 32'h0);     // R7 no flag on wrap

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule